// File: doc/BRIEF.md
# Transition Interval Logger

This block watches a single asynchronous level input and keeps a record of its changes. Each time the synchronized level changes, the block stores one word in an internal buffer. The word holds the new level in its top bit and, in the bits below, the number of clock cycles since the previous change. A host reads the buffer through a simple address-in, data-out port and can see at all times how many entries are valid.

A one-cycle host write strobe, or the active-low reset, starts a new recording. When the buffer is full, recording stops and the stored entries are kept until the next restart. The raw input passes through a two-flop synchronizer, so one asynchronous edge can produce only one entry. Change detection, the stored level and the interval counter all use the same synchronized sample.

Top module: `transition_logger`

## Requirements
- R1: An entry is CNT_W+1 bits wide (32 by default). The top bit holds the synchronized level after the change, and the low CNT_W bits hold the interval count.
- R2: An entry is written, and the write index rises by exactly one, only in a cycle where the synchronized input differs from the stored previous level. While the input is constant the index does not move.
- R3: On a change the interval counter reloads to 1, and otherwise it increments by one. The interval stored for a change is therefore the number of clock cycles between that change and the previous one.
- R4: The interval counter saturates at its all-ones value instead of wrapping, so a long interval reads as all ones.
- R5: Once the write index equals DEPTH, further changes store nothing, earlier entries are left as they were, and the index stays at DEPTH.
- R6: The reset or a host write strobe sets the write index to 0 and the counter to 1, and loads the previous level from the synchronized input. A level held across the restart therefore creates no entry.
- R7: A change on the raw input goes through two synchronizer flops. The write index changes after the third rising clock edge that follows the raw change.
- R8: The read data is registered. It returns the entry at the read address one cycle after the address is given, or zero when the address is at or above the write index seen at that edge. Reset clears it to zero.
- R9: The current write index is always present on an output.
- R10: The level bits of consecutive stored entries alternate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawIn | input | 1 | Asynchronous level being monitored |
| hostWr | input | 1 | Restart strobe, high for one or more cycles |
| rdAddr | input | $clog2(DEPTH+1) | Entry address to read |
| rdData | output | CNT_W+1 | Entry read, one cycle after the address |
| wrIndex | output | $clog2(DEPTH+1) | Number of valid entries |

## Verification
The assertions assume that the reset is held low for at least one clock edge before any check is made, and that rawIn may change at any time but is only ever seen through the synchronizer. The bench changes rawIn and rdAddr only on falling clock edges, holds reset for several cycles so that the synchronizer settles, and uses a short counter width and a small depth so that saturation and a full buffer are reached within a short run. A behavioural model follows the raw stimulus, and its results are compared with both outputs on every cycle.

// File: rtl/tl_pkg.sv
package tl_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // reset or host restart this cycle
    logic change;   // synchronized level differs from previous
    logic store;    // write an entry this cycle
    logic level;    // synchronized level
  } ctrl_t;
endpackage

// File: rtl/tl_ctrl.sv
module tl_ctrl #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic              hostWr,
  output tl_pkg::ctrl_t     ctrl,
  output logic [IDX_W-1:0]  wrPtr
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

  logic syncA, syncB, prevLevel;
  logic restart, change, store;

  // two-flop synchronizer, free running
  always_ff @(posedge clk) begin
    syncA <= rawIn;
    syncB <= syncA;
  end

  always_comb begin
    restart = !rstN || hostWr;
    change  = (syncB != prevLevel) && !restart;
    store   = change && (wrPtr < LIMIT);
    ctrl.restart = restart;
    ctrl.change  = change;
    ctrl.store   = store;
    ctrl.level   = syncB;
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      wrPtr     <= '0;
      prevLevel <= syncB;
    end else begin
      if (change) prevLevel <= syncB;
      if (store)  wrPtr <= wrPtr + 1'b1;
    end
  end

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= LIMIT);
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (store && !hostWr) |=> wrPtr == $past(wrPtr) + 1'b1);
  assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (syncB == prevLevel && !hostWr) |=> $stable(wrPtr));
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr == LIMIT && !hostWr) |=> wrPtr == LIMIT);
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> wrPtr == '0);
  assert_level_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (syncB != prevLevel) |=> prevLevel == $past(syncB));
endmodule

// File: rtl/tl_data.sv
module tl_data #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 31,
  localparam int IDX_W   = $clog2(DEPTH + 1),
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int ENTRY_W = CNT_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tl_pkg::ctrl_t      ctrl,
  input  logic [IDX_W-1:0]   wrPtr,
  input  logic [IDX_W-1:0]   rdAddr,
  output logic [ENTRY_W-1:0] rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]   cnt;
  logic [ENTRY_W-1:0] mem [DEPTH];

  // interval counter
  always_ff @(posedge clk) begin
    if (ctrl.restart || ctrl.change) cnt <= CNT_W'(1);
    else if (cnt != CNT_MAX)         cnt <= cnt + 1'b1;
  end

  // entry storage
  always_ff @(posedge clk) begin
    if (ctrl.store) mem[wrPtr[ADDR_W-1:0]] <= {ctrl.level, cnt};
  end

  // registered readback
  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (rdAddr < wrPtr) rdData <= mem[rdAddr[ADDR_W-1:0]];
    else                    rdData <= '0;
  end

  assert_cnt_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.change |=> cnt == CNT_W'(1));
  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.restart && !ctrl.change && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
  assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.restart && !ctrl.change && cnt == CNT_MAX) |=> cnt == CNT_MAX);
  assert_rd_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr >= wrPtr) |=> rdData == '0);
endmodule

// File: rtl/transition_logger.sv
module transition_logger #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 31,
  localparam int IDX_W   = $clog2(DEPTH + 1),
  localparam int ENTRY_W = CNT_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rawIn,
  input  logic               hostWr,
  input  logic [IDX_W-1:0]   rdAddr,
  output logic [ENTRY_W-1:0] rdData,
  output logic [IDX_W-1:0]   wrIndex
);
  tl_pkg::ctrl_t    ctrl;
  logic [IDX_W-1:0] wrPtr;

  tl_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .hostWr(hostWr),
    .ctrl(ctrl), .wrPtr(wrPtr)
  );

  tl_data #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrPtr(wrPtr),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  assign wrIndex = wrPtr; // R9
endmodule

// File: tb/transition_logger_tb.sv
module transition_logger_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CNT_W = 6;
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam int ENTRY_W = CNT_W + 1;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawIn = 1'b0;
  logic hostWr = 1'b0;
  logic [IDX_W-1:0] rdAddr = '0;
  logic [ENTRY_W-1:0] rdData;
  logic [IDX_W-1:0] wrIndex;

  int checks = 0;
  int fails = 0;

  transition_logger #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .hostWr(hostWr),
    .rdAddr(rdAddr), .rdData(rdData), .wrIndex(wrIndex)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic m1 = 1'b0, m2 = 1'b0, prevM = 1'b0;
  int cntM = 1, idxM = 0;
  logic [ENTRY_W-1:0] memM [DEPTH];
  logic [ENTRY_W-1:0] expRd = '0;

  always @(posedge clk) begin
    if (!rstN) expRd = '0;
    else expRd = (int'(rdAddr) < idxM) ? memM[rdAddr] : '0;
    if (!rstN || hostWr) begin
      idxM = 0; cntM = 1; prevM = m2;
    end else if (m2 != prevM) begin
      if (idxM < DEPTH) begin
        memM[idxM] = {m2, CNT_W'(cntM)};
        idxM++;
      end
      prevM = m2; cntM = 1;
    end else if (cntM < CMAX) cntM++;
    m2 = m1; m1 = rawIn;
  end

  bit modelOn = 1'b0;
  always @(negedge clk) if (modelOn) begin
    chk("R9 wrIndex vs model", wrIndex, idxM);
    chk("R8 rdData vs model", rdData, expRd);
  end

  task automatic toggleAfter(input int n);
    repeat (n) @(negedge clk);
    rawIn = ~rawIn;
  endtask

  task automatic readAt(input int a, output logic [ENTRY_W-1:0] v);
    rdAddr = IDX_W'(a);
    @(negedge clk);
    v = rdData;
  endtask

  initial begin
    logic [ENTRY_W-1:0] v, pv;
    int base;
    repeat (5) @(negedge clk);
    modelOn = 1'b1;
    chk("R6 reset index", wrIndex, 0);
    chk("R8 reset rdData", rdData, 0);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    // R7: synchronizer latency
    base = wrIndex;
    rawIn = 1'b1;
    @(negedge clk); chk("R7 edge1 no entry", wrIndex, base);
    @(negedge clk); chk("R7 edge2 no entry", wrIndex, base);
    @(negedge clk); chk("R7 edge3 entry", wrIndex, base + 1);
    toggleAfter(9);   // e1 level 0, interval 12
    toggleAfter(5);   // e2 level 1, interval 5
    toggleAfter(1);   // e3 level 0, interval 1
    repeat (100) @(negedge clk);
    chk("R2 constant input holds index", wrIndex, 4);
    rawIn = ~rawIn;   // e4 level 1, saturated
    for (int i = 0; i < 5; i++) toggleAfter(3);
    repeat (6) @(negedge clk);
    chk("R5 index stops at depth", wrIndex, DEPTH);
    readAt(1, v); chk("R1 e1 level", v[CNT_W], 0); chk("R3 e1 interval", v[CNT_W-1:0], 12);
    readAt(2, v); chk("R1 e2 level", v[CNT_W], 1); chk("R3 e2 interval", v[CNT_W-1:0], 5);
    readAt(3, v); chk("R3 e3 one-cycle pulse", v[CNT_W-1:0], 1);
    readAt(4, v); chk("R4 e4 saturated", v[CNT_W-1:0], CMAX);
    readAt(7, v); chk("R5 last entry kept", v, {1'b0, CNT_W'(3)});
    readAt(DEPTH, v); chk("R8 out of range zero", v, 0);
    readAt(0, pv);
    for (int i = 1; i < DEPTH; i++) begin
      readAt(i, v);
      chk("R10 levels alternate", v[CNT_W], !pv[CNT_W]);
      pv = v;
    end
    // restart by host strobe
    hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
    chk("R6 strobe clears index", wrIndex, 0);
    readAt(0, v); chk("R8 above index zero", v, 0);
    repeat (10) @(negedge clk);
    chk("R6 held level no entry", wrIndex, 0);
    toggleAfter(2);
    toggleAfter(4);
    repeat (6) @(negedge clk);
    chk("R2 two entries after restart", wrIndex, 2);
    readAt(1, v); chk("R3 interval after restart", v[CNT_W-1:0], 4);
    readAt(2, v); chk("R8 above index zero", v, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule